// File: doc/BRIEF.md
# Floating-Point Operate Instruction Decoder

This block takes a 32-bit floating-point operate instruction and reports what it needs from the register file before any arithmetic starts. It identifies the instruction class, either arithmetic/convert or compare, and pulls out the 9-bit operation code. For each of the three register operands it reports a precision of none, single, double or quad, and whether the value must be unpacked. It also reports the register number of each operand.

It checks that wide operands use aligned register numbers and that compares name no destination. When a check fails, it flags the instruction as illegal and writes a trap-type code into a copy of the floating-point status word.

Instructions enter on a valid/ready stream together with the current status word. One cycle after acceptance the result appears on a registered valid/ready output stream. A new instruction is accepted only when the output register is empty or is being drained in the same cycle (`in_ready = !out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, every output holds its value.

Top module: `fpd_decoder`

## Requirements
- R1: Class detection uses the instruction ANDed with 0xC1F80000. A value of 0x81A00000 selects the arithmetic/convert class (`out_is_cmp`=0). A value of 0x81A80000 selects the compare class (`out_is_cmp`=1). Any other value is unrecognised, and `out_is_cmp` is then 0.
- R2: `out_opcode` always shows instruction bits 13:5. Each operand descriptor is 3 bits: bit 2 is the unpack flag, and bits 1:0 give the size (0 none, 1 single, 2 double, 3 quad). The entries below are written as opcode: rd/rs2/rs1, with S, D and Q for single, double and quad, u for unpack and N for none.
  - Arithmetic class, quad group:
    - 0x043, 0x047, 0x04B, 0x04F: Qu/Qu/Qu
    - 0x02B: Qu/Qu/N
    - 0x06E: Qu/Du/Du
    - 0x0C7: Su/Qu/N
    - 0x0CB: Du/Qu/N
    - 0x0CC: Qu/S/N
    - 0x0CD: Qu/Su/N
    - 0x0CE: Qu/Du/N
    - 0x0D3: S/Qu/N
  - Arithmetic class, single and double group:
    - 0x041, 0x045, 0x049, 0x04D: Su/Su/Su
    - 0x042, 0x046, 0x04A, 0x04E: Du/Du/Du
    - 0x029: Su/Su/N
    - 0x02A: Du/Du/N
    - 0x069: Du/Su/Su
    - 0x0C6: Su/Du/N
    - 0x0C9: Du/Su/N
    - 0x0D1: S/Su/N
    - 0x0D2: S/Du/N
    - 0x0C4: Su/S/N
    - 0x0C8: Du/S/N
    - 0x001, 0x005, 0x009: S/S/N
  - Compare class:
    - 0x051, 0x055: N/Su/Su
    - 0x052, 0x056: N/Du/Du
    - 0x053, 0x057: N/Qu/Qu
- R3: For a recognised instruction, `out_rs1_idx` is bits 18:14, `out_rs2_idx` is bits 4:0 and `out_rd_idx` is bits 29:25.
- R4: An unrecognised instruction gives the following outputs:
  - `out_known`=0 and `out_illegal`=0
  - all three descriptors and all three indices at 0
  - `out_trap`=0
  - `out_status` equal to the accepted status word, unchanged
- R5: A recognised instruction is illegal (`out_illegal`=1, `out_trap`=6) in either of these cases:
  - a quad operand has either of the two low bits of its register number set;
  - a double operand has bit 0 of its register number set.
- R6: A compare instruction whose destination field (bits 29:25) is non-zero is illegal, with `out_trap`=6.
- R7: For a recognised instruction, `out_status` is the accepted status word with bits 16:14 replaced by `out_trap`: 0 when legal, 6 when illegal. All other bits pass through.
- R8: An input is accepted on a clock edge where `in_valid && in_ready`. Its result shows with `out_valid`=1 after that edge. `in_ready` is low while a result waits with `out_ready` low, and the outputs stay stable during that wait.
- R9: After reset, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Decoder can take an instruction |
| in_insn | input | 32 | Instruction word |
| in_status | input | 32 | Status word to update |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_known | output | 1 | Class and opcode recognised |
| out_is_cmp | output | 1 | Compare class |
| out_illegal | output | 1 | Register check failed |
| out_opcode | output | 9 | Operation code field |
| out_rd_desc | output | 3 | Destination descriptor {unpack,size} |
| out_rs1_desc | output | 3 | First source descriptor |
| out_rs2_desc | output | 3 | Second source descriptor |
| out_rd_idx | output | 5 | Destination register number |
| out_rs1_idx | output | 5 | First source register number |
| out_rs2_idx | output | 5 | Second source register number |
| out_trap | output | 3 | Trap-type code (0 or 6) |
| out_status | output | 32 | Updated status word |

## Verification
The hardest situation to reach is one where a single operand is misaligned while the other operands of the same opcode are aligned. The trap must come from exactly that operand and from no other. The bench sweeps all 512 opcode values in both classes. For each value it applies an aligned register set, then moves one operand at a time onto a register number with bit 0 set, and then onto one with bit 1 set. This separates quad checks from double checks, and it also covers non-zero compare destinations. A second hard case is a result stalled by `out_ready` while the next instruction is already offered. A dedicated task holds that stall for several cycles before releasing it.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  localparam int OPC_W   = 9;
  localparam int OPC_LSB = 5;
  localparam int IDX_W   = 5;
  localparam int RS1_LSB = 14;
  localparam int RS2_LSB = 0;
  localparam int RD_LSB  = 25;

  localparam logic [31:0] CLS_MASK  = 32'hC1F8_0000;
  localparam logic [31:0] CLS_ARITH = 32'h81A0_0000;
  localparam logic [31:0] CLS_CMP   = 32'h81A8_0000;

  localparam logic [1:0] SZ_NONE   = 2'd0;
  localparam logic [1:0] SZ_SINGLE = 2'd1;
  localparam logic [1:0] SZ_DOUBLE = 2'd2;
  localparam logic [1:0] SZ_QUAD   = 2'd3;

  typedef struct packed {
    logic       unpack;
    logic [1:0] size;
  } opdesc_t;

  typedef struct packed {
    logic    known;
    opdesc_t rd;
    opdesc_t rs2;
    opdesc_t rs1;
  } optab_t;

  function automatic optab_t mk_entry(input logic [1:0] rd_sz, input logic rd_u,
                                      input logic [1:0] b_sz, input logic b_u,
                                      input logic [1:0] a_sz, input logic a_u);
    optab_t t;
    t.known      = 1'b1;
    t.rd.size    = rd_sz;
    t.rd.unpack  = rd_u;
    t.rs2.size   = b_sz;
    t.rs2.unpack = b_u;
    t.rs1.size   = a_sz;
    t.rs1.unpack = a_u;
    return t;
  endfunction
endpackage

// File: rtl/fpd_class_decode.sv
module fpd_class_decode
  import fpd_pkg::*;
#(
  parameter int INSN_W = 32
) (
  input  logic [INSN_W-1:0] insn,
  output logic              is_arith,
  output logic              is_cmp,
  output logic [OPC_W-1:0]  opcode
);
  logic [INSN_W-1:0] masked;

  always_comb begin
    masked   = insn & INSN_W'(CLS_MASK);
    is_arith = (masked == INSN_W'(CLS_ARITH));
    is_cmp   = (masked == INSN_W'(CLS_CMP));
    opcode   = insn[OPC_LSB +: OPC_W];
  end
endmodule

// File: rtl/fpd_op_table.sv
module fpd_op_table
  import fpd_pkg::*;
(
  input  logic             is_arith,
  input  logic             is_cmp,
  input  logic [OPC_W-1:0] opcode,
  output optab_t           tab
);
  localparam logic [1:0] N = SZ_NONE;
  localparam logic [1:0] S = SZ_SINGLE;
  localparam logic [1:0] D = SZ_DOUBLE;
  localparam logic [1:0] Q = SZ_QUAD;

  always_comb begin
    tab = '0;
    if (is_arith) begin
      case (opcode)
        9'h043, 9'h047, 9'h04B, 9'h04F: tab = mk_entry(Q, 1'b1, Q, 1'b1, Q, 1'b1);
        9'h02B:                         tab = mk_entry(Q, 1'b1, Q, 1'b1, N, 1'b0);
        9'h06E:                         tab = mk_entry(Q, 1'b1, D, 1'b1, D, 1'b1);
        9'h0C7:                         tab = mk_entry(S, 1'b1, Q, 1'b1, N, 1'b0);
        9'h0CB:                         tab = mk_entry(D, 1'b1, Q, 1'b1, N, 1'b0);
        9'h0CC:                         tab = mk_entry(Q, 1'b1, S, 1'b0, N, 1'b0);
        9'h0CD:                         tab = mk_entry(Q, 1'b1, S, 1'b1, N, 1'b0);
        9'h0CE:                         tab = mk_entry(Q, 1'b1, D, 1'b1, N, 1'b0);
        9'h0D3:                         tab = mk_entry(S, 1'b0, Q, 1'b1, N, 1'b0);
        9'h041, 9'h045, 9'h049, 9'h04D: tab = mk_entry(S, 1'b1, S, 1'b1, S, 1'b1);
        9'h042, 9'h046, 9'h04A, 9'h04E: tab = mk_entry(D, 1'b1, D, 1'b1, D, 1'b1);
        9'h029:                         tab = mk_entry(S, 1'b1, S, 1'b1, N, 1'b0);
        9'h02A:                         tab = mk_entry(D, 1'b1, D, 1'b1, N, 1'b0);
        9'h069:                         tab = mk_entry(D, 1'b1, S, 1'b1, S, 1'b1);
        9'h0C6:                         tab = mk_entry(S, 1'b1, D, 1'b1, N, 1'b0);
        9'h0C9:                         tab = mk_entry(D, 1'b1, S, 1'b1, N, 1'b0);
        9'h0D1:                         tab = mk_entry(S, 1'b0, S, 1'b1, N, 1'b0);
        9'h0D2:                         tab = mk_entry(S, 1'b0, D, 1'b1, N, 1'b0);
        9'h0C4:                         tab = mk_entry(S, 1'b1, S, 1'b0, N, 1'b0);
        9'h0C8:                         tab = mk_entry(D, 1'b1, S, 1'b0, N, 1'b0);
        9'h001, 9'h005, 9'h009:         tab = mk_entry(S, 1'b0, S, 1'b0, N, 1'b0);
        default:                        tab = '0;
      endcase
    end else if (is_cmp) begin
      case (opcode)
        9'h051, 9'h055: tab = mk_entry(N, 1'b0, S, 1'b1, S, 1'b1);
        9'h052, 9'h056: tab = mk_entry(N, 1'b0, D, 1'b1, D, 1'b1);
        9'h053, 9'h057: tab = mk_entry(N, 1'b0, Q, 1'b1, Q, 1'b1);
        default:        tab = '0;
      endcase
    end
  end
endmodule

// File: rtl/fpd_reg_check.sv
module fpd_reg_check
  import fpd_pkg::*;
#(
  parameter bit IS_DEST = 1'b0
) (
  input  opdesc_t          desc,
  input  logic [IDX_W-1:0] idx,
  output logic             bad
);
  always_comb begin
    case (desc.size)
      SZ_QUAD:   bad = |idx[1:0];
      SZ_DOUBLE: bad = idx[0];
      SZ_NONE:   bad = IS_DEST ? (idx != '0) : 1'b0;
      default:   bad = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpd_decoder.sv
module fpd_decoder
  import fpd_pkg::*;
#(
  parameter int INSN_W    = 32,
  parameter int STAT_W    = 32,
  parameter int TT_LSB    = 14,
  parameter int TT_W      = 3,
  parameter int TT_BADREG = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [STAT_W-1:0] in_status,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_known,
  output logic              out_is_cmp,
  output logic              out_illegal,
  output logic [OPC_W-1:0]  out_opcode,
  output logic [2:0]        out_rd_desc,
  output logic [2:0]        out_rs1_desc,
  output logic [2:0]        out_rs2_desc,
  output logic [IDX_W-1:0]  out_rd_idx,
  output logic [IDX_W-1:0]  out_rs1_idx,
  output logic [IDX_W-1:0]  out_rs2_idx,
  output logic [TT_W-1:0]   out_trap,
  output logic [STAT_W-1:0] out_status
);
  localparam int NUM_OPS = 3;
  localparam logic [TT_W-1:0] TT_CODE = TT_W'(TT_BADREG);

  logic             is_arith, is_cmp;
  logic [OPC_W-1:0] opcode;
  optab_t           tab;

  fpd_class_decode #(.INSN_W(INSN_W)) u_class (
    .insn(in_insn), .is_arith(is_arith), .is_cmp(is_cmp), .opcode(opcode)
  );

  fpd_op_table u_table (
    .is_arith(is_arith), .is_cmp(is_cmp), .opcode(opcode), .tab(tab)
  );

  // Operand 0: rs1, 1: rs2, 2: rd
  opdesc_t          op_desc [NUM_OPS];
  logic [IDX_W-1:0] op_idx  [NUM_OPS];
  logic [NUM_OPS-1:0] op_bad;

  always_comb begin
    op_desc[0] = tab.rs1;
    op_desc[1] = tab.rs2;
    op_desc[2] = tab.rd;
    op_idx[0]  = in_insn[RS1_LSB +: IDX_W];
    op_idx[1]  = in_insn[RS2_LSB +: IDX_W];
    op_idx[2]  = in_insn[RD_LSB  +: IDX_W];
  end

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_chk
    fpd_reg_check #(.IS_DEST(g == NUM_OPS - 1)) u_chk (
      .desc(op_desc[g]), .idx(op_idx[g]), .bad(op_bad[g])
    );
  end

  logic              illegal_nx;
  logic [TT_W-1:0]   trap_nx;
  logic [STAT_W-1:0] stat_nx;

  always_comb begin
    illegal_nx = tab.known & (|op_bad);
    trap_nx    = illegal_nx ? TT_CODE : '0;
    stat_nx    = in_status;
    if (tab.known) stat_nx[TT_LSB +: TT_W] = trap_nx;
  end

  logic accept;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_known    <= 1'b0;
      out_is_cmp   <= 1'b0;
      out_illegal  <= 1'b0;
      out_opcode   <= '0;
      out_rd_desc  <= '0;
      out_rs1_desc <= '0;
      out_rs2_desc <= '0;
      out_rd_idx   <= '0;
      out_rs1_idx  <= '0;
      out_rs2_idx  <= '0;
      out_trap     <= '0;
      out_status   <= '0;
    end else if (accept) begin
      out_valid    <= 1'b1;
      out_known    <= tab.known;
      out_is_cmp   <= tab.known & is_cmp;
      out_illegal  <= illegal_nx;
      out_opcode   <= opcode;
      out_rd_desc  <= tab.rd;
      out_rs1_desc <= tab.rs1;
      out_rs2_desc <= tab.rs2;
      out_rd_idx   <= tab.known ? op_idx[2] : '0;
      out_rs1_idx  <= tab.known ? op_idx[0] : '0;
      out_rs2_idx  <= tab.known ? op_idx[1] : '0;
      out_trap     <= trap_nx;
      out_status   <= stat_nx;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  // R8: stalled result holds
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_status) &&
      $stable(out_opcode) && $stable(out_illegal) && $stable(out_rd_idx));

  // R8: accepted input produces a result
  a_r8_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R5: illegal result carries the trap code in both places
  a_r5_trap_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_trap == TT_CODE &&
      out_status[TT_LSB +: TT_W] == TT_CODE);

  // R4: unrecognised result is empty
  a_r4_unknown_empty: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_known |-> !out_illegal && !out_is_cmp &&
      out_rd_desc == '0 && out_rs1_desc == '0 && out_rs2_desc == '0 && out_trap == '0);

  // R6: compare with non-zero destination is illegal
  a_r6_cmp_dest: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_cmp && out_rd_idx != '0 |-> out_illegal);
endmodule

// File: tb/fpd_decoder_test.sv
module fpd_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_insn = '0;
  logic [31:0] in_status = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_known, out_is_cmp, out_illegal;
  logic [8:0]  out_opcode;
  logic [2:0]  out_rd_desc, out_rs1_desc, out_rs2_desc;
  logic [4:0]  out_rd_idx, out_rs1_idx, out_rs2_idx;
  logic [2:0]  out_trap;
  logic [31:0] out_status;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  fpd_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_status(in_status), .out_valid(out_valid),
    .out_ready(out_ready), .out_known(out_known), .out_is_cmp(out_is_cmp),
    .out_illegal(out_illegal), .out_opcode(out_opcode), .out_rd_desc(out_rd_desc),
    .out_rs1_desc(out_rs1_desc), .out_rs2_desc(out_rs2_desc), .out_rd_idx(out_rd_idx),
    .out_rs1_idx(out_rs1_idx), .out_rs2_idx(out_rs2_idx), .out_trap(out_trap),
    .out_status(out_status)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // {known, rd{u,sz}, rs2{u,sz}, rs1{u,sz}} from the R2 table
  function automatic logic [9:0] e(input int rs, input int ru, input int bs, input int bu,
                                   input int as_, input int au);
    return {1'b1, ru[0], rs[1:0], bu[0], bs[1:0], au[0], as_[1:0]};
  endfunction

  function automatic logic [9:0] ref_tab(input bit cmp, input logic [8:0] op);
    if (!cmp) begin
      case (op)
        9'h043, 9'h047, 9'h04B, 9'h04F: return e(3,1,3,1,3,1);
        9'h02B: return e(3,1,3,1,0,0);
        9'h06E: return e(3,1,2,1,2,1);
        9'h0C7: return e(1,1,3,1,0,0);
        9'h0CB: return e(2,1,3,1,0,0);
        9'h0CC: return e(3,1,1,0,0,0);
        9'h0CD: return e(3,1,1,1,0,0);
        9'h0CE: return e(3,1,2,1,0,0);
        9'h0D3: return e(1,0,3,1,0,0);
        9'h041, 9'h045, 9'h049, 9'h04D: return e(1,1,1,1,1,1);
        9'h042, 9'h046, 9'h04A, 9'h04E: return e(2,1,2,1,2,1);
        9'h029: return e(1,1,1,1,0,0);
        9'h02A: return e(2,1,2,1,0,0);
        9'h069: return e(2,1,1,1,1,1);
        9'h0C6: return e(1,1,2,1,0,0);
        9'h0C9: return e(2,1,1,1,0,0);
        9'h0D1: return e(1,0,1,1,0,0);
        9'h0D2: return e(1,0,2,1,0,0);
        9'h0C4: return e(1,1,1,0,0,0);
        9'h0C8: return e(2,1,1,0,0,0);
        9'h001, 9'h005, 9'h009: return e(1,0,1,0,0,0);
        default: return '0;
      endcase
    end else begin
      case (op)
        9'h051, 9'h055: return e(0,0,1,1,1,1);
        9'h052, 9'h056: return e(0,0,2,1,2,1);
        9'h053, 9'h057: return e(0,0,3,1,3,1);
        default: return '0;
      endcase
    end
  endfunction

  function automatic bit misaligned(input logic [1:0] sz, input logic [4:0] idx, input bit dest);
    case (sz)
      2'd3: return |idx[1:0];
      2'd2: return idx[0];
      2'd0: return dest && (idx != 0);
      default: return 1'b0;
    endcase
  endfunction

  task automatic issue(input logic [31:0] insn, input logic [31:0] st);
    @(negedge clk);
    in_valid  = 1'b1;
    in_insn   = insn;
    in_status = st;
    @(posedge clk);
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 out_valid after reset", 64'(out_valid), 64'd0);
    chk("R9 in_ready after reset", 64'(in_ready), 64'd1);
  endtask

  // Decode one instruction and compare every field with the requirement model
  task automatic run_one(input bit cmp, input logic [8:0] op, input logic [4:0] rd,
                         input logic [4:0] a, input logic [4:0] b, input logic [31:0] st);
    logic [31:0] insn;
    logic [9:0]  t;
    bit          kn, ill;
    logic [2:0]  trap;
    logic [31:0] st_exp;
    insn = (cmp ? 32'h81A8_0000 : 32'h81A0_0000) | {2'b0, rd, 25'b0} |
           {13'b0, a, 14'b0} | {18'b0, op, 5'b0} | {27'b0, b};
    t  = ref_tab(cmp, op);
    kn = t[9];
    ill = kn && (misaligned(t[1:0], a, 1'b0) || misaligned(t[4:3], b, 1'b0) ||
                 misaligned(t[7:6], rd, 1'b1));
    trap = ill ? 3'd6 : 3'd0;
    st_exp = st;
    if (kn) st_exp[16:14] = trap;
    issue(insn, st);
    chk("R8 out_valid", 64'(out_valid), 64'd1);
    chk("R2 opcode", 64'(out_opcode), 64'(op));
    if (!kn) begin
      chk("R4 unrecognised known/cmp/illegal/trap",
          64'({out_known, out_is_cmp, out_illegal, out_trap}), 64'd0);
      chk("R4 unrecognised descriptors and indices",
          64'({out_rd_desc, out_rs2_desc, out_rs1_desc, out_rd_idx, out_rs1_idx, out_rs2_idx}), 64'd0);
      chk("R4 status unchanged", 64'(out_status), 64'(st));
    end else begin
      chk("R1 class", 64'({out_known, out_is_cmp}), 64'({1'b1, cmp}));
      chk("R2 descriptors", 64'({out_rd_desc, out_rs2_desc, out_rs1_desc}), 64'(t[8:0]));
      chk("R3 indices", 64'({out_rd_idx, out_rs1_idx, out_rs2_idx}), 64'({rd, a, b}));
      if (cmp && rd != 0)
        chk("R6 compare dest illegal/trap", 64'({out_illegal, out_trap}), 64'({ill, trap}));
      else
        chk("R5 alignment illegal/trap", 64'({out_illegal, out_trap}), 64'({ill, trap}));
      chk("R7 status trap field", 64'(out_status), 64'(st_exp));
    end
  endtask

  task automatic t_sweep;
    for (int c = 0; c < 2; c++) begin
      for (int o = 0; o < 512; o++) begin
        logic [4:0]  rd0;
        logic [31:0] st;
        rd0 = (c == 1) ? 5'd0 : 5'd8;
        st  = o[0] ? 32'hFFFF_FFFF : 32'h0001_2345;
        run_one(c[0], o[8:0], rd0,   5'd16, 5'd12, st);
        run_one(c[0], o[8:0], rd0,   5'd17, 5'd12, st);
        run_one(c[0], o[8:0], rd0,   5'd18, 5'd12, st);
        run_one(c[0], o[8:0], rd0,   5'd16, 5'd13, st);
        run_one(c[0], o[8:0], rd0,   5'd16, 5'd14, st);
        run_one(c[0], o[8:0], 5'd9,  5'd16, 5'd12, st);
        run_one(c[0], o[8:0], 5'd10, 5'd16, 5'd12, st);
      end
    end
  endtask

  // R1: class mask mismatches are unrecognised even with a valid opcode
  task automatic t_mask;
    issue(32'h81B0_0000 | (32'h041 << 5), 32'h0000_C000);
    chk("R1 other op3 unrecognised", 64'(out_known), 64'd0);
    chk("R4 other op3 status kept", 64'(out_status), 64'h0000_C000);
    issue(32'hC1A0_0000 | (32'h042 << 5), 32'h0);
    chk("R1 bit30 set unrecognised", 64'(out_known), 64'd0);
    issue(32'h81A0_0000 | (32'h051 << 5), 32'h0);
    chk("R1 compare code in arith class", 64'(out_known), 64'd0);
  endtask

  // R8: back-pressure holds result and blocks input
  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_insn   = 32'h81A0_0000 | (32'h041 << 5);
    in_status = 32'h0;
    @(posedge clk);
    @(negedge clk);
    in_insn = 32'h81A0_0000 | (32'h042 << 5) | (32'd1 << 14);
    chk("R8 in_ready low in stall", 64'(in_ready), 64'd0);
    chk("R8 first result shown", 64'({out_valid, out_opcode, out_illegal}), 64'({1'b1, 9'h041, 1'b0}));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 result held in stall", 64'({out_valid, out_opcode, out_illegal, in_ready}),
          64'({1'b1, 9'h041, 1'b0, 1'b0}));
    end
    out_ready = 1'b1;
    #1;
    chk("R8 in_ready follows out_ready", 64'(in_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 second result after release", 64'({out_valid, out_opcode, out_illegal, out_trap}),
        64'({1'b1, 9'h042, 1'b1, 3'd6}));
    @(negedge clk);
    chk("R8 output drained", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_mask;
    t_backpressure;
    t_sweep;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule